// File: doc/BRIEF.md
# Field-Gap Downlink Bit Demodulator

This block recovers the bits that a 125 kHz RFID reader sends to a tag by briefly switching its field off. The input is a clean, already synchronized level: 1 while the carrier is present, 0 while it is stopped. The block reacts only to changes of that level and measures every interval in clock cycles. It compares each interval against thresholds that are given in carrier periods and scaled by an integer clocks-per-period parameter.

A long field stop moves the block from its search state into write mode. While in write mode, each field-off interval longer than the gap threshold ends a bit cell. The length of the on-interval before that gap decides the output. A medium interval gives one zero. A long interval gives a run of ones, one per whole one-step length, and may end with a trailing zero. If the field stays free of qualifying gaps beyond the idle limit, write mode ends and a frame-end pulse is issued. Frame parsing happens downstream.

Top module: `fgap_demod`

## Requirements
- R1: A synchronous reset, whether at start-up or in the middle of write mode, returns the block to search with `write_mode`, `bit_valid` and `frame_end` low.
- R2: In search, a rising edge that ends a field-off interval strictly longer than `entry_stop_min`×CPF cycles sets `write_mode` from the next cycle. An interval of exactly that length leaves the block in search. Entering write mode emits no bit.
- R3: In write mode, a field-off interval no longer than `gap_min`×CPF cycles is ignored. It emits nothing, and the on-interval keeps running through it, so the on-interval is measured from the end of the last qualifying gap to the falling edge that starts the next one.
- R4: An on-interval L with `zero_lo`×CPF < L < `zero_hi`×CPF yields one bit with value 0. The first bit decoded at a gap is valid in the cycle right after the clock edge that samples the gap's rising edge.
- R5: Otherwise, if `one_step`×CPF < L < `idle_lim`×CPF, the block emits floor(L / (`one_step`×CPF)) bits of value 1, one per consecutive cycle.
- R6: After such a run of ones, if the remainder L − n×`one_step`×CPF lies strictly inside the zero window, one further bit of value 0 follows in the very next cycle, and nothing follows a zero.
- R7: An on-interval that matches neither window emits no bit.
- R8: In write mode, once more than `idle_lim`×CPF cycles have passed since the end of the last qualifying gap, `frame_end` pulses for one cycle and `write_mode` drops in that same cycle.
- R9: Thresholds are live inputs and take effect on the next decode. When the zero window and the ones condition overlap, the zero window wins.
- R10: `bit_valid` is asserted only in write mode, and `frame_end` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| env_in | input | 1 | Field level, 1 = carrier on |
| entry_stop_min | input | TW | Minimum entry stop length, carrier periods |
| gap_min | input | TW | Minimum write-gap length, carrier periods |
| zero_lo | input | TW | Zero window lower bound (exclusive), carrier periods |
| zero_hi | input | TW | Zero window upper bound (exclusive), carrier periods |
| one_step | input | TW | Length of one "1" bit, carrier periods |
| idle_lim | input | TW | Idle limit that closes a frame, carrier periods |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_value | output | 1 | Value of the decoded bit |
| frame_end | output | 1 | One-cycle strobe when write mode ends |
| write_mode | output | 1 | High while in write mode |

## Verification
The hardest case to reach from the ports is an on-interval that spans several one-steps and leaves a remainder inside the zero window, so that a run of ones ends with a tail zero. A close second is an interval broken by a sub-threshold dip that must not split it. The stimulus builds every frame from on-interval lengths chosen in carrier periods: directed frames place those lengths on the window edges and insert a short dip, and random frames draw lengths across the whole range while keeping each interval plus its gap under the idle limit. A live change of the one-step and zero-window thresholds then drives the overlap case where the zero window takes precedence.

// File: rtl/fgap_demod.sv
module fgap_demod #(
  parameter int CPF = 4,
  parameter int TW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          env_in,
  input  logic [TW-1:0] entry_stop_min,
  input  logic [TW-1:0] gap_min,
  input  logic [TW-1:0] zero_lo,
  input  logic [TW-1:0] zero_hi,
  input  logic [TW-1:0] one_step,
  input  logic [TW-1:0] idle_lim,
  output logic          bit_valid,
  output logic          bit_value,
  output logic          frame_end,
  output logic          write_mode
);
  localparam int CW = TW + $clog2(CPF + 1) + 1;
  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t scale(input logic [TW-1:0] v);
    return cnt_t'(v) * cnt_t'(CPF);
  endfunction

  function automatic cnt_t sat_inc(input cnt_t v);
    return (v == '1) ? v : v + cnt_t'(1);
  endfunction

  cnt_t entry_c, gap_c, zlo_c, zhi_c, one_c, idle_c;
  assign entry_c = scale(entry_stop_min);
  assign gap_c   = scale(gap_min);
  assign zlo_c   = scale(zero_lo);
  assign zhi_c   = scale(zero_hi);
  assign one_c   = scale(one_step);
  assign idle_c  = scale(idle_lim);

  logic lvl_q, busy;
  cnt_t run_cnt, since_gap, on_mark, rem;

  wire edge_w   = env_in ^ lvl_q;
  wire rise     = edge_w & env_in;
  wire fall     = edge_w & ~env_in;
  wire idle_hit = write_mode & (since_gap > idle_c);
  wire gap_end  = write_mode & ~idle_hit & rise & (run_cnt > gap_c);
  wire mark_zero = (on_mark > zlo_c) && (on_mark < zhi_c);
  wire mark_ones = (on_mark > one_c) && (on_mark < idle_c);
  wire rem_zero  = (rem > zlo_c) && (rem < zhi_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q      <= 1'b1;
      run_cnt    <= '0;
      since_gap  <= '0;
      on_mark    <= '0;
      rem        <= '0;
      busy       <= 1'b0;
      write_mode <= 1'b0;
      bit_valid  <= 1'b0;
      bit_value  <= 1'b0;
      frame_end  <= 1'b0;
    end else begin
      lvl_q     <= env_in;
      run_cnt   <= edge_w ? cnt_t'(1) : sat_inc(run_cnt);
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
      frame_end <= 1'b0;

      if (!write_mode) begin
        if (rise && run_cnt > entry_c) begin
          write_mode <= 1'b1;
          since_gap  <= cnt_t'(1);
        end
      end else if (idle_hit) begin
        write_mode <= 1'b0;
        frame_end  <= 1'b1;
        busy       <= 1'b0;
      end else begin
        since_gap <= gap_end ? cnt_t'(1) : sat_inc(since_gap);
        if (fall) on_mark <= since_gap;
      end

      if (gap_end) begin
        busy <= 1'b0;
        if (mark_zero) begin
          bit_valid <= 1'b1;
        end else if (mark_ones) begin
          bit_valid <= 1'b1;
          bit_value <= 1'b1;
          rem       <= on_mark - one_c;
          busy      <= 1'b1;
        end
      end else if (busy && !idle_hit) begin
        if (rem >= one_c && one_c != '0) begin
          bit_valid <= 1'b1;
          bit_value <= 1'b1;
          rem       <= rem - one_c;
        end else begin
          busy <= 1'b0;
          if (rem_zero) bit_valid <= 1'b1;
        end
      end
    end
  end
endmodule

module fgap_demod_chk (
  input logic clk,
  input logic rst,
  input logic env_in,
  input logic bit_valid,
  input logic bit_value,
  input logic frame_end,
  input logic write_mode
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !write_mode && !bit_valid && !frame_end);
  // R2
  entry_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(write_mode) |-> $past(env_in) && !bit_valid);
  // R4
  first_bit_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_valid) |-> $past(env_in) && !$past(env_in, 2));
  // R6
  nothing_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid && !bit_value |=> !bit_valid);
  // R8
  idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !write_mode && $past(write_mode));
  // R10
  bits_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> write_mode);
  // R10
  frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);
endmodule

bind fgap_demod fgap_demod_chk chk_i (
  .clk(clk), .rst(rst), .env_in(env_in), .bit_valid(bit_valid),
  .bit_value(bit_value), .frame_end(frame_end), .write_mode(write_mode)
);

// File: tb/fgap_demod_tb.sv
module fgap_demod_tb_top;
  localparam int C  = 4;
  localparam int TW = 9;
  typedef bit bq_t[$];

  logic clk = 1'b0, rst = 1'b1, env = 1'b1;
  logic [TW-1:0] t_entry = 40, t_gap = 12, t_zlo = 15, t_zhi = 27, t_one = 32, t_idle = 300;
  logic bit_valid, bit_value, frame_end, write_mode;

  int checks = 0, errors = 0, fe_cnt = 0;
  bq_t got_q;
  int L_arr[$], D_arr[$];
  string T_arr[$];

  always #4 clk = ~clk;

  fgap_demod #(.CPF(C), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .env_in(env),
    .entry_stop_min(t_entry), .gap_min(t_gap), .zero_lo(t_zlo), .zero_hi(t_zhi),
    .one_step(t_one), .idle_lim(t_idle),
    .bit_valid(bit_valid), .bit_value(bit_value), .frame_end(frame_end), .write_mode(write_mode)
  );

  always @(negedge clk) if (!rst) begin
    if (bit_valid) got_q.push_back(bit_value);
    if (frame_end) fe_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bq_t model(input int L);
    bq_t q;
    int zl = t_zlo * C, zh = t_zhi * C, o = t_one * C, id = t_idle * C;
    if (L > zl && L < zh) q.push_back(1'b0);
    else if (L > o && L < id) begin
      int n = L / o;
      int r = L - n * o;
      for (int i = 0; i < n; i++) q.push_back(1'b1);
      if (r > zl && r < zh) q.push_back(1'b0);
    end
    return q;
  endfunction

  function automatic int pack(input bq_t q);
    int v = 1;
    foreach (q[i]) v = (v << 1) | int'(q[i]);
    return v;
  endfunction

  task automatic hold(input logic lvl, input int n);
    env = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic high_rest(input int n, input int d);
    if (d == 0) hold(1'b1, n);
    else begin
      int a = (n - d) / 2;
      hold(1'b1, a);
      hold(1'b0, d);
      hold(1'b1, n - d - a);
    end
  endtask

  task automatic first_bit(input bq_t e, input string tag);
    if (e.size() == 0) chk(bit_valid == 1'b0, {tag, " R4 no bit at gap end"}, int'(bit_valid), 0);
    else chk(bit_valid && bit_value == e[0], {tag, " R4 first bit timing"},
             int'({bit_valid, bit_value}), int'({1'b1, e[0]}));
  endtask

  task automatic cmp_q(input bq_t e, input string tag);
    chk(pack(got_q) == pack(e), {tag, " bit sequence"}, pack(got_q), pack(e));
    got_q = {};
  endtask

  task automatic play_frame(input int entry_len, input string ftag);
    bq_t prevq;
    string ptag;
    fe_cnt = 0;
    got_q = {};
    hold(1'b0, entry_len);
    ptag = {ftag, " R2 entry"};
    for (int k = 0; k < L_arr.size(); k++) begin
      env = 1'b1;
      @(negedge clk);
      first_bit(prevq, ptag);
      if (k == 0) chk(write_mode == 1'b1, {ftag, " R2 entered write mode"}, int'(write_mode), 1);
      high_rest(L_arr[k] - 1, D_arr[k]);
      cmp_q(prevq, ptag);
      prevq = model(L_arr[k]);
      ptag = T_arr[k];
      hold(1'b0, (13 + int'($urandom % 20)) * C);
    end
    env = 1'b1;
    @(negedge clk);
    first_bit(prevq, ptag);
    hold(1'b1, int'(t_idle) * C + 10);
    cmp_q(prevq, ptag);
    chk(fe_cnt == 1, {ftag, " R8 one frame end"}, fe_cnt, 1);
    chk(write_mode == 1'b0, {ftag, " R8 back to search"}, int'(write_mode), 0);
    L_arr = {}; D_arr = {}; T_arr = {};
  endtask

  task automatic add_iv(input int periods, input int dip, input string tag);
    L_arr.push_back(periods * C);
    D_arr.push_back(dip);
    T_arr.push_back(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!write_mode && !bit_valid && !frame_end, "R1 reset state",
        int'({write_mode, bit_valid, frame_end}), 0);
    rst = 1'b0;
    void'($urandom(32'h5EED));
    hold(1'b1, 20);

    hold(1'b0, 40 * C);
    env = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(write_mode == 1'b0, "R2 stop of exactly the limit stays in search", int'(write_mode), 0);
    hold(1'b1, 20);

    add_iv(20, 0, "R4 zero window");
    add_iv(100, 0, "R5 run of three ones");
    add_iv(84, 0, "R6 ones with tail zero");
    add_iv(29, 0, "R7 between windows");
    add_iv(10, 0, "R7 below zero window");
    add_iv(45, 20, "R3 short dip ignored");
    add_iv(26, 0, "R4 zero near upper edge");
    play_frame(40 * C + 1, "directed");

    t_one = 20; t_zhi = 25;
    add_iv(45, 0, "R9 new one step");
    add_iv(22, 0, "R9 zero window precedence");
    play_frame(41 * C, "live thresholds");
    t_one = 32; t_zhi = 27;

    for (int f = 0; f < 8; f++) begin
      int n = 3 + int'($urandom % 4);
      for (int k = 0; k < n; k++) begin
        L_arr.push_back((5 + int'($urandom % 246)) * C + int'($urandom % C));
        D_arr.push_back(0);
        T_arr.push_back("R5 random interval");
      end
      play_frame((41 + int'($urandom % 10)) * C + int'($urandom % C), "random");
    end

    hold(1'b0, 50 * C);
    hold(1'b1, 30);
    chk(write_mode == 1'b1, "R1 in write mode before reset", int'(write_mode), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!write_mode && !frame_end, "R1 reset in write mode", int'({write_mode, frame_end}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule